// File: doc/BRIEF.md
# CMI Transmit Serializer with Selectable Framer Width

This block takes data from a framer and turns it into a coded-mark-inversion line stream. The framer can deliver one bit at a time or a parallel word of four or eight bits. Two mode pins choose between these ports at runtime. The whole block runs in one clock domain at the half-bit rate, so each data bit occupies two consecutive line symbols. At a nominal 155.52 Mbit/s data rate the clock runs at twice that rate.

The block produces a strobe that paces the framer. In the cycle where the strobe is high, the block captures the value on the selected data input. That word is sent on the line most significant bit first, with no gap after the word in flight.

A change of the mode pins is not acted on at once. It waits for the next word boundary. There the block sends a short run of encoded zeros to flush the pipeline, and only then takes up the new width.

Top module: `cmi_tx_serializer`

## Requirements
- R1: `par_sel_i` high selects the parallel port and low selects the serial port. While serial, `wide_sel_i` has no effect on the line stream, on the strobe spacing, or on when flushes occur.
- R2: With `par_sel_i`=1 and `wide_sel_i`=1, all of `word_i[7:0]` is sent, and consecutive strobes are 16 clock cycles apart.
- R3: With `par_sel_i`=1 and `wide_sel_i`=0, only `word_i[3:0]` is sent, `word_i[7:4]` has no effect, and consecutive strobes are 8 clock cycles apart.
- R4: The first data bit of a parallel word on the line is its top bit: `word_i[7]` in 8-bit mode and `word_i[3]` in 4-bit mode. Lower bits follow in descending order.
- R5: A data 0 is sent as the symbol 0 in its first half-bit cycle and 1 in its second.
- R6: A data 1 holds one level for both of its half-bit cycles, and that level is the opposite of the level used by the previous data 1. The remembered level is 0 after reset, so the first 1 is sent as 1,1.
- R7: The strobe is high only in the first half-bit cycle of the last bit of the current word, and never in two successive cycles. The first symbol of the captured word follows that last bit directly, two cycles after the strobe cycle.
- R8: If the normalised mode on the pins differs from the active mode at a strobe opportunity, the strobe is withheld. At the word boundary the block sends FLUSH_BITS encoded zeros and switches to the new mode. The next strobe comes 2·Wold + 2·FLUSH_BITS cycles after the previous one, where Wold is the old width.
- R9: After reset the active mode is serial and the line carries one encoded zero (0 then 1). The strobe is high in the first cycle after reset when the pins select serial.
- R10: In serial mode `ser_bit_i` is captured at each strobe, and strobes come every 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_sel_i | input | 1 | 1 selects the parallel port, 0 the serial port |
| wide_sel_i | input | 1 | In parallel mode, 1 selects 8 bits and 0 selects 4 bits |
| ser_bit_i | input | 1 | Serial data bit, captured at a strobe |
| word_i | input | 8 | Parallel data word, captured at a strobe |
| word_stb_o | output | 1 | Capture strobe for the framer |
| line_o | output | 1 | CMI symbol stream, one symbol per cycle |

## Verification
Two functions can land in the same candidate cycle: supplying the next word and deciding on a mode switch. The bench provokes this by changing the mode pins in the cycle right after a strobe, so the very next candidate sees a mismatch. The outcome is judged in two ways. The scoreboard queue must show the old word, then exactly FLUSH_BITS encoded zeros, then the first word of the new width. The gap between strobes must equal 2·Wold + 2·FLUSH_BITS. The closing candidate of a flush is the second overlap: there the flush ends and a strobe is issued together, and the bench checks both the symbols and the spacing around it.

// File: rtl/cmi_tx_pkg.sv
package cmi_tx_pkg;

  localparam int WORD_W = 8;

  typedef enum logic [1:0] {
    MODE_SER = 2'd0,
    MODE_N4  = 2'd1,
    MODE_N8  = 2'd2
  } lane_mode_e;

  // Serial mode ignores the width pin.
  function automatic lane_mode_e decode_mode(input logic par, input logic wide);
    if (!par)     return MODE_SER;
    else if (wide) return MODE_N8;
    else          return MODE_N4;
  endfunction

  // Data bits carried per strobe in each mode.
  function automatic logic [3:0] mode_width(input lane_mode_e m);
    case (m)
      MODE_N8: return 4'd8;
      MODE_N4: return 4'd4;
      default: return 4'd1;
    endcase
  endfunction

  // Left-align the captured bits so the shifter always sends bit 7 first.
  function automatic logic [WORD_W-1:0] capture_word(input lane_mode_e m,
                                                     input logic [WORD_W-1:0] w,
                                                     input logic s);
    case (m)
      MODE_N8: return w;
      MODE_N4: return {w[3:0], 4'b0000};
      default: return {s, 7'b0000000};
    endcase
  endfunction

  // Symbol pair {first half, second half} for one data bit.
  function automatic logic [1:0] cmi_pair(input logic d, input logic prev_lvl);
    if (d) return {~prev_lvl, ~prev_lvl};
    else   return 2'b01;
  endfunction

endpackage

// File: rtl/cmi_tx_mode_ctl.sv
module cmi_tx_mode_ctl
  import cmi_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       par_sel,
  input  logic       wide_sel,
  input  logic       cand,
  input  logic       boundary,
  output lane_mode_e active_mode,
  output logic       mode_match,
  output logic       flush_go
);
  lane_mode_e req_mode;
  lane_mode_e pend_mode;
  logic       pend_flush;

  assign req_mode   = decode_mode(par_sel, wide_sel);
  assign mode_match = (req_mode == active_mode);
  assign flush_go   = boundary && pend_flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_mode <= MODE_SER;
      pend_mode   <= MODE_SER;
      pend_flush  <= 1'b0;
    end else begin
      if (cand) begin
        pend_flush <= !mode_match;
        pend_mode  <= req_mode;
      end
      if (boundary && pend_flush) active_mode <= pend_mode;
    end
  end
endmodule

// File: rtl/cmi_tx_shifter.sv
module cmi_tx_shifter
  import cmi_tx_pkg::*;
#(
  parameter int FLUSH_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_stb,
  input  logic              flush_go,
  input  lane_mode_e        active_mode,
  input  logic [WORD_W-1:0] word_i,
  input  logic              ser_bit_i,
  output logic              half,
  output logic              last_bit,
  output logic              cur_bit,
  output logic              in_flush
);
  localparam int MAX_RUN = (FLUSH_BITS > WORD_W) ? FLUSH_BITS : WORD_W;
  localparam int CNT_W   = $clog2(MAX_RUN + 1);

  logic [WORD_W-1:0] shreg_q;
  logic [WORD_W-1:0] hold_q;
  logic [CNT_W-1:0]  left_q;

  assign last_bit = (left_q == CNT_W'(1));
  assign cur_bit  = shreg_q[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half     <= 1'b0;
      shreg_q  <= '0;
      hold_q   <= '0;
      left_q   <= CNT_W'(1);
      in_flush <= 1'b0;
    end else begin
      half <= ~half;
      if (word_stb) hold_q <= capture_word(active_mode, word_i, ser_bit_i);
      if (half) begin
        if (last_bit) begin
          if (flush_go) begin
            shreg_q  <= '0;
            left_q   <= CNT_W'(FLUSH_BITS);
            in_flush <= 1'b1;
          end else begin
            shreg_q  <= hold_q;
            left_q   <= CNT_W'(mode_width(active_mode));
            in_flush <= 1'b0;
          end
        end else begin
          shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
          left_q  <= left_q - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/cmi_tx_encoder.sv
module cmi_tx_encoder
  import cmi_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic half,
  input  logic cur_bit,
  output logic line_o
);
  logic       prev_lvl_q;
  logic [1:0] pair;

  assign pair   = cmi_pair(cur_bit, prev_lvl_q);
  assign line_o = half ? pair[0] : pair[1];

  // The remembered level advances at the end of each data 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              prev_lvl_q <= 1'b0;
    else if (half && cur_bit) prev_lvl_q <= ~prev_lvl_q;
  end
endmodule

// File: rtl/cmi_tx_serializer.sv
module cmi_tx_serializer
  import cmi_tx_pkg::*;
#(
  parameter int FLUSH_BITS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       par_sel_i,
  input  logic       wide_sel_i,
  input  logic       ser_bit_i,
  input  logic [7:0] word_i,
  output logic       word_stb_o,
  output logic       line_o
);
  // Named internal events, also used by the bound checker.
  logic       half_w;
  logic       last_bit_w;
  logic       cur_bit_w;
  logic       in_flush_w;
  logic       cand_w;
  logic       boundary_w;
  logic       match_w;
  logic       flush_go_w;
  lane_mode_e active_mode_w;

  assign cand_w     = !half_w && last_bit_w;
  assign boundary_w = half_w && last_bit_w;
  assign word_stb_o = cand_w && match_w;

  cmi_tx_mode_ctl u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .par_sel     (par_sel_i),
    .wide_sel    (wide_sel_i),
    .cand        (cand_w),
    .boundary    (boundary_w),
    .active_mode (active_mode_w),
    .mode_match  (match_w),
    .flush_go    (flush_go_w)
  );

  cmi_tx_shifter #(.FLUSH_BITS(FLUSH_BITS)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_stb    (word_stb_o),
    .flush_go    (flush_go_w),
    .active_mode (active_mode_w),
    .word_i      (word_i),
    .ser_bit_i   (ser_bit_i),
    .half        (half_w),
    .last_bit    (last_bit_w),
    .cur_bit     (cur_bit_w),
    .in_flush    (in_flush_w)
  );

  cmi_tx_encoder u_enc (
    .clk     (clk),
    .rst_n   (rst_n),
    .half    (half_w),
    .cur_bit (cur_bit_w),
    .line_o  (line_o)
  );
endmodule

// File: rtl/cmi_tx_checker.sv
module cmi_tx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       line_o,
  input logic       word_stb_o,
  input logic       half,
  input logic       last_bit,
  input logic       cur_bit,
  input logic       in_flush,
  input logic       boundary,
  input logic [1:0] active_mode
);
  logic prev_one_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                prev_one_q <= 1'b0;
    else if (!half && cur_bit) prev_one_q <= line_o;
  end

  a_r5_zero_first_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!half && !cur_bit) |-> !line_o);

  a_r5_zero_second_high: assert property (@(posedge clk) disable iff (!rst_n)
    (half && !cur_bit) |-> line_o);

  a_r6_one_holds_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!half && cur_bit) |=> (line_o == $past(line_o)));

  a_r6_one_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    (!half && cur_bit) |-> (line_o != prev_one_q));

  a_r7_stb_on_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb_o |-> (!half && last_bit));

  a_r7_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb_o |=> !word_stb_o);

  a_r8_mode_only_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(active_mode));

  a_r8_flush_sends_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_flush |-> !cur_bit);

  a_r1_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    active_mode != 2'b11);
endmodule

bind cmi_tx_serializer cmi_tx_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .line_o      (line_o),
  .word_stb_o  (word_stb_o),
  .half        (half_w),
  .last_bit    (last_bit_w),
  .cur_bit     (cur_bit_w),
  .in_flush    (in_flush_w),
  .boundary    (boundary_w),
  .active_mode (active_mode_w)
);

// File: tb/cmi_tx_serializer_tb.sv
module cmi_tx_serializer_tb;
  localparam int FLUSH_BITS = 2;
  localparam int NSEG       = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       par_sel = 1'b0;
  logic       wide_sel = 1'b0;
  logic       ser_bit = 1'b0;
  logic [7:0] word = 8'h00;
  logic       word_stb;
  logic       line;

  always #5 clk = ~clk;

  cmi_tx_serializer #(.FLUSH_BITS(FLUSH_BITS)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .par_sel_i  (par_sel),
    .wide_sel_i (wide_sel),
    .ser_bit_i  (ser_bit),
    .word_i     (word),
    .word_stb_o (word_stb),
    .line_o     (line)
  );

  int    checks = 0;
  int    errors = 0;
  logic  exp_q[$];
  string tag_q[$];
  logic  lvl = 1'b0;

  // Segments: pins and number of words; segment 1 toggles only the width pin in serial (R1).
  int seg_par [NSEG] = '{0, 0, 1, 1, 0, 1, 1};
  int seg_wide[NSEG] = '{0, 1, 1, 0, 1, 0, 1};
  int seg_n   [NSEG] = '{20, 12, 12, 12, 10, 6, 8};
  string seg_tag[NSEG] = '{"R10", "R1", "R2 R4", "R3 R4", "R10", "R3 R4", "R2 R4"};

  function automatic int width_of(input int p, input int w);
    return (p != 0) ? ((w != 0) ? 8 : 4) : 1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Driver side: push the expected symbol pair of one data bit.
  task automatic push_bit(input logic d, input string t);
    if (d) begin
      lvl = ~lvl;
      exp_q.push_back(lvl); tag_q.push_back({t, " R6"});
      exp_q.push_back(lvl); tag_q.push_back({t, " R6"});
    end else begin
      exp_q.push_back(1'b0); tag_q.push_back({t, " R5"});
      exp_q.push_back(1'b1); tag_q.push_back({t, " R5"});
    end
  endtask

  task automatic drive_word(input int seg, input int idx);
    int w;
    logic [7:0] d;
    w = width_of(seg_par[seg], seg_wide[seg]);
    d = (idx % 5 == 0) ? 8'hFF : 8'($urandom);
    if (w == 1) begin
      ser_bit = d[0];
      word    = 8'($urandom);
      push_bit(d[0], seg_tag[seg]);
    end else if (w == 4) begin
      ser_bit = 1'($urandom);
      word    = {4'($urandom), d[3:0]};
      for (int i = 3; i >= 0; i--) push_bit(d[i], seg_tag[seg]);
    end else begin
      ser_bit = 1'($urandom);
      word    = d;
      for (int i = 7; i >= 0; i--) push_bit(d[i], seg_tag[seg]);
    end
  endtask

  initial begin
    int    cyc = 0;
    int    seg = 0;
    int    cnt = 0;
    int    last_stb = 0;
    int    last_w = 1;
    bit    have_last = 0;
    bit    flushed = 0;
    bit    apply = 0;
    bit    done = 0;
    int    w;
    string ptag;

    par_sel = 1'(seg_par[0]);
    wide_sel = 1'(seg_wide[0]);
    push_bit(1'b0, "R9");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // First cycle after reset: strobe in serial mode and line low (R9).
    check(word_stb === 1'b1, "R9", "strobe after reset", int'(word_stb), 1);
    check(line === 1'b0, "R9", "line after reset", int'(line), 0);

    while (!done) begin
      // Monitor side: pop and compare one symbol.
      if (exp_q.size() == 0) begin
        check(1'b0, "R7", "queue empty, stream gap", int'(line), -1);
      end else begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(line === e, t, "line symbol", int'(line), int'(e));
      end

      if (apply) begin
        int nw;
        w  = width_of(int'(par_sel), int'(wide_sel));
        nw = width_of(seg_par[seg], seg_wide[seg]);
        par_sel  = 1'(seg_par[seg]);
        wide_sel = 1'(seg_wide[seg]);
        if (nw != w) begin
          for (int i = 0; i < FLUSH_BITS; i++) push_bit(1'b0, "R8");
          flushed = 1;
        end
        apply = 0;
      end

      if (word_stb === 1'b1) begin
        w = width_of(int'(par_sel), int'(wide_sel));
        if (have_last) begin
          if (flushed)
            check(cyc - last_stb == 2*last_w + 2*FLUSH_BITS, "R8",
                  "strobe spacing across flush", cyc - last_stb, 2*last_w + 2*FLUSH_BITS);
          else begin
            ptag = (w == 8) ? "R2 R7" : (w == 4) ? "R3 R7" : "R10 R7";
            check(cyc - last_stb == 2*w, ptag, "strobe spacing", cyc - last_stb, 2*w);
          end
        end
        have_last = 1;
        flushed   = 0;
        last_stb  = cyc;
        last_w    = w;
        drive_word(seg, cnt);
        cnt++;
        if (cnt == seg_n[seg]) begin
          cnt = 0;
          seg++;
          if (seg == NSEG) done = 1;
          else apply = 1;
        end
      end

      if (cyc > 20000) begin
        check(1'b0, "R7", "watchdog expired", cyc, 20000);
        done = 1;
      end
      @(negedge clk);
      cyc++;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule